// File: doc/BRIEF.md
# Two-Layer Stacked Hit Correlator

This block pairs hits from two closely spaced sensor layers to pick out stiff tracks. Each layer is a 128-channel column that is split into 32 groups of four channels. On every bunch crossing, each layer presents a short list of hits. A hit is a 5-bit group address and a 4-bit pattern that shows which of the four channels fired. The block takes one crossing per clock and has a fixed latency.

Processing runs in two steps. First, a width filter removes any pattern that is not a single channel or a pair of adjacent channels. It keeps the first surviving hits of each layer and counts the surplus. Second, each kept lower-layer hit is compared with every kept upper-layer hit. The patterns are compared directly and the group addresses are compared within a small window, with no decoding to strip numbers. Each lower hit that finds a partner becomes one stub word. The stub words of a crossing are presented together, sorted by address, ready to be shifted off the module.

Top module: `stub_correlator`

## Requirements
- R1: While `rst` is high, and on the first sampling point after it, every stub slot is zero and `ovf_cnt` is zero.
- R2: A hit whose pattern (bit 3 down to bit 0) has exactly one bit set, or exactly two adjacent bits set, passes the width filter. Patterns that are empty, have three or more bits set, or have two bits that are not adjacent (such as 1010) are discarded as if absent.
- R3: Per layer and per crossing, at most 2 filtered hits are kept, taken in ascending list-slot order. Each further filtered hit is dropped and adds one to `ovf_cnt`. A hit discarded by R2 does not count toward the limit or the counter.
- R4: A lower hit and an upper hit pair up when their patterns are identical and their group addresses differ by 0 or 1. A difference of 2 or more fails, and the address does not wrap from 31 to 0.
- R5: Each kept lower hit with at least one partner yields exactly one stub word. The word has bit 9 = valid, bits 8:4 = the lower group address and bits 3:0 = the pattern. Slot k of `stub_o` occupies bits 10k+9 to 10k.
- R6: The stubs of one crossing fill the slots from slot 0 upward in ascending lower-address order, and the unused slots read zero.
- R7: Stubs for a crossing presented before clock edge n appear after edge n+1. Consecutive crossings on consecutive cycles do not mix.
- R8: `ovf_cnt` saturates at its maximum (255 by default) and holds there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bunch crossing per cycle |
| rst | input | 1 | Synchronous active-high reset |
| lo_vld | input | N_IN | Lower-layer list slot occupied |
| lo_addr | input | N_IN*5 | Lower-layer group addresses, slot s at bits 5s+4:5s |
| lo_pat | input | N_IN*4 | Lower-layer hit patterns, slot s at bits 4s+3:4s |
| up_vld | input | N_IN | Upper-layer list slot occupied |
| up_addr | input | N_IN*5 | Upper-layer group addresses |
| up_pat | input | N_IN*4 | Upper-layer hit patterns |
| stub_o | output | N_KEEP*10 | Correlated stub words of one crossing |
| ovf_cnt | output | OCNT_W | Saturating count of dropped surplus hits |

## Verification
The bench checks the edges of the address window: a difference of 1 in both directions, a difference of 2, and groups 0 and 31. An off-by-one comparator, or one that wraps, would create or lose stubs at exactly these points. It sends the patterns 1110, 1010 and 0000 and also the valid edge pairs 1100 and 0011, so that a loose or over-strict width test shows up as spurious or missing stubs. It puts an invalid hit ahead of the surplus hits, which would expose a filter that spends its keep budget on rejected patterns or counts them as overflow. It also checks that out-of-order matches come out sorted and packed into the low slots, that back-to-back crossings stay separate, and that the counter stops at 255 instead of wrapping.

// File: rtl/stubcorr_pkg.sv
package stubcorr_pkg;
  localparam int ADDR_W = 5;
  localparam int PAT_W  = 4;
  localparam int SW     = 1 + ADDR_W + PAT_W;

  typedef struct packed {
    logic              v;
    logic [ADDR_W-1:0] a;
    logic [PAT_W-1:0]  p;
  } hit_t;

  // single channel or two neighbouring channels
  function automatic logic pat_ok(input logic [PAT_W-1:0] p);
    logic ok;
    ok = 1'b0;
    for (int i = 0; i < PAT_W; i++) begin
      if (p == (PAT_W'(1) << i)) ok = 1'b1;
      if (i < PAT_W - 1 && p == (PAT_W'(3) << i)) ok = 1'b1;
    end
    return ok;
  endfunction

  function automatic logic addr_near(input logic [ADDR_W-1:0] x,
                                     input logic [ADDR_W-1:0] y,
                                     input int tol);
    logic [ADDR_W-1:0] d;
    d = (x > y) ? (x - y) : (y - x);
    return int'(d) <= tol;
  endfunction
endpackage

// File: rtl/hit_filter.sv
module hit_filter
  import stubcorr_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_KEEP = 2,
  localparam int DW    = $clog2(N_IN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  hit_t          in_h [N_IN],
  output hit_t          kept [N_KEEP],
  output logic [DW-1:0] drops
);
  hit_t          sel [N_KEEP];
  logic [DW-1:0] ndrop;

  always_comb begin
    int n;
    n = 0;
    ndrop = '0;
    for (int k = 0; k < N_KEEP; k++) sel[k] = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (in_h[i].v && pat_ok(in_h[i].p)) begin
        if (n < N_KEEP) begin
          sel[n] = in_h[i];
          n++;
        end else begin
          ndrop = ndrop + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_KEEP; k++) kept[k] <= '0;
      drops <= '0;
    end else begin
      for (int k = 0; k < N_KEEP; k++) kept[k] <= sel[k];
      drops <= ndrop;
    end
  end

  generate
    for (genvar k = 0; k < N_KEEP; k++) begin : g_chk
      // R2: only narrow clusters leave the filter
      a_r2_kept_narrow: assert property (@(posedge clk) disable iff (rst)
        kept[k].v |-> pat_ok(kept[k].p));
      if (k > 0) begin : g_pack
        // R3: kept hits fill from slot 0
        a_r3_kept_packed: assert property (@(posedge clk) disable iff (rst)
          kept[k].v |-> kept[k-1].v);
      end
    end
  endgenerate
endmodule

// File: rtl/stub_match.sv
module stub_match
  import stubcorr_pkg::*;
#(
  parameter int N_KEEP = 2,
  parameter int TOL    = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  hit_t                 lo [N_KEEP],
  input  hit_t                 up [N_KEEP],
  output logic [N_KEEP*SW-1:0] stubs
);
  logic [N_KEEP-1:0]    hit;
  logic [N_KEEP*SW-1:0] nxt;

  always_comb begin
    for (int i = 0; i < N_KEEP; i++) begin
      hit[i] = 1'b0;
      for (int j = 0; j < N_KEEP; j++)
        if (lo[i].v && up[j].v && lo[i].p == up[j].p &&
            addr_near(lo[i].a, up[j].a, TOL))
          hit[i] = 1'b1;
    end
  end

  // rank each matched lower hit among the matched ones, ties by index
  always_comb begin
    nxt = '0;
    for (int i = 0; i < N_KEEP; i++) begin
      int r;
      r = 0;
      for (int j = 0; j < N_KEEP; j++)
        if (hit[j] && (lo[j].a < lo[i].a || (lo[j].a == lo[i].a && j < i)))
          r++;
      if (hit[i]) nxt[r*SW +: SW] = {1'b1, lo[i].a, lo[i].p};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stubs <= '0;
    else     stubs <= nxt;
  end

  generate
    for (genvar k = 0; k + 1 < N_KEEP; k++) begin : g_ord
      // R6: packed low and ascending by address
      a_r6_stub_order: assert property (@(posedge clk) disable iff (rst)
        stubs[(k+1)*SW + SW-1] |->
          (stubs[k*SW + SW-1] &&
           stubs[k*SW + PAT_W +: ADDR_W] <= stubs[(k+1)*SW + PAT_W +: ADDR_W]));
    end
    for (genvar k = 0; k < N_KEEP; k++) begin : g_w
      // R5: a stub always carries a narrow pattern
      a_r5_stub_pattern: assert property (@(posedge clk) disable iff (rst)
        stubs[k*SW + SW-1] |-> pat_ok(stubs[k*SW +: PAT_W]));
    end
  endgenerate
endmodule

// File: rtl/stub_correlator.sv
module stub_correlator
  import stubcorr_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_KEEP = 2,
  parameter int TOL    = 1,
  parameter int OCNT_W = 8,
  localparam int DW    = $clog2(N_IN + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IN-1:0]          lo_vld,
  input  logic [N_IN*ADDR_W-1:0]   lo_addr,
  input  logic [N_IN*PAT_W-1:0]    lo_pat,
  input  logic [N_IN-1:0]          up_vld,
  input  logic [N_IN*ADDR_W-1:0]   up_addr,
  input  logic [N_IN*PAT_W-1:0]    up_pat,
  output logic [N_KEEP*SW-1:0]     stub_o,
  output logic [OCNT_W-1:0]        ovf_cnt
);
  localparam logic [OCNT_W:0] CMAX = {1'b0, {OCNT_W{1'b1}}};

  hit_t          lo_in [N_IN];
  hit_t          up_in [N_IN];
  hit_t          lo_k  [N_KEEP];
  hit_t          up_k  [N_KEEP];
  logic [DW-1:0] lo_d, up_d;
  logic [OCNT_W:0] sum;

  generate
    for (genvar s = 0; s < N_IN; s++) begin : g_unpack
      assign lo_in[s] = '{v: lo_vld[s], a: lo_addr[s*ADDR_W +: ADDR_W],
                          p: lo_pat[s*PAT_W +: PAT_W]};
      assign up_in[s] = '{v: up_vld[s], a: up_addr[s*ADDR_W +: ADDR_W],
                          p: up_pat[s*PAT_W +: PAT_W]};
    end
  endgenerate

  hit_filter #(.N_IN(N_IN), .N_KEEP(N_KEEP)) u_flt_lo (
    .clk(clk), .rst(rst), .in_h(lo_in), .kept(lo_k), .drops(lo_d));

  hit_filter #(.N_IN(N_IN), .N_KEEP(N_KEEP)) u_flt_up (
    .clk(clk), .rst(rst), .in_h(up_in), .kept(up_k), .drops(up_d));

  stub_match #(.N_KEEP(N_KEEP), .TOL(TOL)) u_match (
    .clk(clk), .rst(rst), .lo(lo_k), .up(up_k), .stubs(stub_o));

  assign sum = {1'b0, ovf_cnt} + (OCNT_W+1)'(lo_d) + (OCNT_W+1)'(up_d);

  always_ff @(posedge clk) begin
    if (rst)             ovf_cnt <= '0;
    else if (sum > CMAX) ovf_cnt <= CMAX[OCNT_W-1:0];
    else                 ovf_cnt <= sum[OCNT_W-1:0];
  end

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (stub_o == '0 && ovf_cnt == '0));

  // R8: counter never moves backward (no wrap)
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ovf_cnt >= $past(ovf_cnt));
endmodule

// File: tb/tb_stub_correlator.sv
module tb_stub_correlator;
  localparam int N_IN = 4;
  localparam int NK   = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N_IN-1:0]   lo_vld = '0, up_vld = '0;
  logic [N_IN*5-1:0] lo_addr = '0, up_addr = '0;
  logic [N_IN*4-1:0] lo_pat = '0, up_pat = '0;
  logic [NK*10-1:0]  stub_o;
  logic [7:0]        ovf_cnt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  stub_correlator dut (
    .clk(clk), .rst(rst),
    .lo_vld(lo_vld), .lo_addr(lo_addr), .lo_pat(lo_pat),
    .up_vld(up_vld), .up_addr(up_addr), .up_pat(up_pat),
    .stub_o(stub_o), .ovf_cnt(ovf_cnt));

  function automatic logic [9:0] w(input logic [4:0] a, input logic [3:0] p);
    return {1'b1, a, p};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr();
    lo_vld = '0; up_vld = '0; lo_addr = '0; up_addr = '0; lo_pat = '0; up_pat = '0;
  endtask

  task automatic put(input bit upper, input int s, input logic [4:0] a, input logic [3:0] p);
    if (upper) begin up_vld[s] = 1'b1; up_addr[s*5 +: 5] = a; up_pat[s*4 +: 4] = p; end
    else       begin lo_vld[s] = 1'b1; lo_addr[s*5 +: 5] = a; lo_pat[s*4 +: 4] = p; end
  endtask

  // inputs already loaded: hold one cycle, then sample after two edges
  task automatic run_and_check(input string tag, input logic [9:0] e0, input logic [9:0] e1);
    @(negedge clk); clr();
    @(negedge clk);
    chk({tag, " slot0"}, 32'(stub_o[9:0]), 32'(e0));
    chk({tag, " slot1"}, 32'(stub_o[19:10]), 32'(e1));
  endtask

  task automatic t_reset();
    chk("R1 stubs at reset", 32'(stub_o), 0);
    chk("R1 ovf at reset", 32'(ovf_cnt), 0);
  endtask

  task automatic t_basic();
    @(negedge clk); put(0, 0, 5'd3, 4'b0100); put(1, 0, 5'd3, 4'b0100);
    run_and_check("R5 R7 same group", w(5'd3, 4'b0100), '0);
  endtask

  task automatic t_window();
    @(negedge clk); put(0, 0, 5'd10, 4'b0010); put(1, 0, 5'd11, 4'b0010);
    run_and_check("R4 diff +1", w(5'd10, 4'b0010), '0);
    @(negedge clk); put(0, 0, 5'd10, 4'b0010); put(1, 0, 5'd9, 4'b0010);
    run_and_check("R4 diff -1", w(5'd10, 4'b0010), '0);
    @(negedge clk); put(0, 0, 5'd10, 4'b0010); put(1, 0, 5'd12, 4'b0010);
    run_and_check("R4 diff 2 fails", '0, '0);
    @(negedge clk); put(0, 0, 5'd0, 4'b1000); put(1, 0, 5'd31, 4'b1000);
    run_and_check("R4 no wrap", '0, '0);
    @(negedge clk); put(0, 0, 5'd7, 4'b0100); put(1, 0, 5'd7, 4'b0010);
    run_and_check("R4 pattern mismatch", '0, '0);
  endtask

  task automatic t_width();
    @(negedge clk); put(0, 0, 5'd5, 4'b1110); put(1, 0, 5'd5, 4'b1110);
    run_and_check("R2 three wide", '0, '0);
    @(negedge clk); put(0, 0, 5'd5, 4'b1010); put(1, 0, 5'd5, 4'b1010);
    run_and_check("R2 non adjacent", '0, '0);
    @(negedge clk); put(0, 0, 5'd5, 4'b0000); put(1, 0, 5'd5, 4'b0000);
    run_and_check("R2 empty", '0, '0);
    @(negedge clk); put(0, 0, 5'd5, 4'b1100); put(1, 0, 5'd6, 4'b1100);
    put(0, 1, 5'd20, 4'b0011); put(1, 1, 5'd20, 4'b0011);
    run_and_check("R2 pairs pass", w(5'd5, 4'b1100), w(5'd20, 4'b0011));
  endtask

  task automatic t_order();
    @(negedge clk); put(0, 0, 5'd20, 4'b1000); put(0, 1, 5'd5, 4'b0001);
    put(1, 0, 5'd5, 4'b0001); put(1, 1, 5'd21, 4'b1000);
    run_and_check("R6 sorted", w(5'd5, 4'b0001), w(5'd20, 4'b1000));
    @(negedge clk); put(0, 0, 5'd2, 4'b1000); put(0, 1, 5'd9, 4'b0001);
    put(1, 0, 5'd9, 4'b0001);
    run_and_check("R6 packed low", w(5'd9, 4'b0001), '0);
  endtask

  task automatic t_overflow();
    @(negedge clk);
    put(0, 0, 5'd2, 4'b1110); put(0, 1, 5'd4, 4'b0001);
    put(0, 2, 5'd6, 4'b0010); put(0, 3, 5'd9, 4'b0100);
    put(1, 0, 5'd4, 4'b0001); put(1, 1, 5'd9, 4'b0100);
    run_and_check("R3 keep first two", w(5'd4, 4'b0001), '0);
    chk("R3 one dropped", 32'(ovf_cnt), 1);
    @(negedge clk);
    put(1, 0, 5'd1, 4'b1000); put(1, 1, 5'd2, 4'b1000);
    put(1, 2, 5'd14, 4'b0100); put(1, 3, 5'd25, 4'b0100);
    put(0, 0, 5'd14, 4'b0100);
    run_and_check("R3 upper surplus ignored", '0, '0);
    chk("R3 upper drops counted", 32'(ovf_cnt), 3);
  endtask

  task automatic t_stream();
    @(negedge clk); put(0, 0, 5'd12, 4'b0110); put(1, 0, 5'd12, 4'b0110);
    @(negedge clk); clr(); put(0, 0, 5'd30, 4'b0001); put(1, 0, 5'd31, 4'b0001);
    @(negedge clk); clr();
    chk("R7 first crossing", 32'(stub_o), 32'(w(5'd12, 4'b0110)));
    @(negedge clk);
    chk("R7 second crossing", 32'(stub_o), 32'(w(5'd30, 4'b0001)));
  endtask

  task automatic t_saturate();
    for (int c = 0; c < 70; c++) begin
      @(negedge clk);
      for (int s = 0; s < N_IN; s++) begin
        put(0, s, 5'(s), 4'b0001); put(1, s, 5'(s + 8), 4'b1000);
      end
    end
    @(negedge clk); clr();
    @(negedge clk);
    chk("R8 saturated", 32'(ovf_cnt), 255);
    @(negedge clk); put(0, 0, 5'd1, 4'b0001); put(0, 1, 5'd2, 4'b0001); put(0, 2, 5'd3, 4'b0001);
    run_and_check("R8 still clean", '0, '0);
    chk("R8 holds", 32'(ovf_cnt), 255);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_window();
    t_width();
    t_order();
    t_overflow();
    t_stream();
    t_saturate();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule